// File: doc/BRIEF.md
# Framed serial sample output port

This block turns a stream of parallel I and Q filter samples into two serial data lanes. Each lane is paired with a divided bit clock and a periodic frame strobe. The bit period is a programmable number of input clocks. The strobe repeats every programmed number of bit periods, and each word goes out most significant bit first, a programmed number of bit periods after its strobe. The frame period is set independently of the sample rate, so the port can drop samples. It takes only the newest valid sample at the start of each word, which gives decimation at the output.

Framing is anchored by a sync input picked from eight sources. A rising edge on the selected source restarts the divider and the frame counters. A single-cycle pulse and a held level have the same effect, because only the low-to-high change counts. The Q lane can carry a neighbouring channel's Q sample in place of this channel's own. Three output-enable bits let the pad ring float the strobe and data pins.

The control sequence has three states. `ST_IDLE` follows reset and holds until the first sync edge. A restart moves the block to `ST_LEAD` when the advance is non-zero, or straight to `ST_DATA` when it is zero. `ST_LEAD` moves to `ST_DATA` on the bit tick that uses up the advance. A restart in any state re-enters `ST_LEAD` or `ST_DATA` in the same way.

Top module: `serial_frame_tx`

## Requirements
- R1: Each word holds the L = `cfg_len`+1 most significant sample bits, sent MSB first, one bit per bit period. Word bits past the sample width (24 by default) are sent as 0.
- R2: The strobe `fs_out` is high for exactly one bit period out of every P bit periods. P is `cfg_interval`, and a value of 0 is treated as 1.
- R3: A bit period lasts `cfg_div`+1 input clocks. Once framing has started, `ser_clk` is high for the first floor((`cfg_div`+1)/2) clocks of each bit period and low for the rest.
- R4: The first data bit of each frame comes A = `cfg_adv` bit periods after that frame's strobe. Both data lanes are low during the A bit periods that follow a restart.
- R5: Suppose `sync_in[cfg_sync_sel]` is sampled high at clock edge t after being low at edge t-1. Then the counters restart at edge t+3 and the first strobe goes high at edge t+3+(`cfg_div`+1). The unselected sync bits have no effect.
- R6: A selected sync held high gives exactly one restart. Only a new low-to-high change restarts the framing again.
- R7: At the start of each word the port captures the last sample presented with `smp_valid` before that clock edge. Samples that arrive between word starts are dropped.
- R8: When `cfg_adj_q` is 1, the Q lane sends `adj_q` instead of `smp_q`.
- R9: When L exceeds P, only the first P word bits are sent before the next word starts. When L is less than P, the lanes are low for the remaining bit periods of the frame.
- R10: `pin_oe` is the inverse of `cfg_hiz`. Bit 0 belongs to the strobe pin, bit 1 to the I data pin and bit 2 to the Q data pin.
- R11: After reset and until the first selected sync edge, `fs_out`, `dout_i` and `dout_q` stay low.
- R12: A sync edge in the middle of a frame drives the strobe and both lanes low at the restart edge and realigns all framing to the new edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| smp_valid | input | 1 | New sample present on `smp_i`/`smp_q`/`adj_q` |
| smp_i | input | 24 | I sample of this channel |
| smp_q | input | 24 | Q sample of this channel |
| adj_q | input | 24 | Q sample of the neighbouring channel |
| sync_in | input | 8 | Candidate sync sources |
| cfg_interval | input | 7 | Frame period in bit periods (0 counts as 1) |
| cfg_len | input | 5 | Word length minus one |
| cfg_div | input | 4 | Bit period in input clocks, minus one |
| cfg_adv | input | 2 | Strobe lead over first data bit, in bit periods |
| cfg_sync_sel | input | 3 | Index of the active sync source |
| cfg_adj_q | input | 1 | Send neighbouring Q on the Q lane |
| cfg_hiz | input | 3 | Float request: strobe, I, Q |
| ser_clk | output | 1 | Divided bit clock |
| fs_out | output | 1 | Frame strobe |
| dout_i | output | 1 | Serial I lane |
| dout_q | output | 1 | Serial Q lane |
| pin_oe | output | 3 | Pad output enables: strobe, I, Q |

## Verification
The hardest case is a word that wraps past the next strobe while the strobe also leads the data. The word must be cut at exactly P bits even though the next word only starts A bits after that strobe. The bench reaches this with a short frame, a long word and a non-zero advance, while samples change every clock. A level sync held for hundreds of clocks, and a second pulse landing mid-word, check that the framing restarts only on edges. A per-clock model computes every strobe, lane bit and bit-clock level directly from the restart time and the settings.

// File: rtl/sft_pkg.sv
package sft_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LEAD = 2'd1,
        ST_DATA = 2'd2
    } sft_state_e;

    localparam int unsigned NLANE = 2;
    localparam int unsigned NPIN  = 3;
endpackage

// File: rtl/sft_sync_edge.sv
module sft_sync_edge #(
    parameter int NSYNC = 8,
    parameter int SEL_W = $clog2(NSYNC)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NSYNC-1:0] sync_in,
    input  logic [SEL_W-1:0] sel,
    output logic             restart
);
    logic [NSYNC-1:0] cap_q;
    logic             sel_q;
    logic             sel_d;

    // capture, select, delay, then register the low-to-high change
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_q   <= '0;
            sel_q   <= 1'b0;
            sel_d   <= 1'b0;
            restart <= 1'b0;
        end else begin
            cap_q   <= sync_in;
            sel_q   <= cap_q[sel];
            sel_d   <= sel_q;
            restart <= sel_q & ~sel_d;
        end
    end

    // a held level may not produce back-to-back restarts
    assert_one_restart_R6: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> !restart);
endmodule

// File: rtl/sft_bit_div.sv
module sft_bit_div #(
    parameter int DIV_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic [DIV_W-1:0] div_m1,
    output logic             tick,
    output logic             ser_clk
);
    logic [DIV_W-1:0] cnt_q;
    logic [DIV_W-1:0] cnt_n;
    logic [DIV_W:0]   half;
    logic             wrap;

    assign wrap = (cnt_q >= div_m1);
    assign tick = wrap & ~restart;
    assign half = ({1'b0, div_m1} + 1'b1) >> 1;

    always_comb begin
        if (restart || wrap) cnt_n = '0;
        else                 cnt_n = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            ser_clk <= 1'b0;
        end else begin
            cnt_q   <= cnt_n;
            ser_clk <= ({1'b0, cnt_n} < half);
        end
    end

    // after a tick the counter starts over, so only a zero divider ticks again
    assert_bit_spacing_R3: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> (!tick || div_m1 == '0));
endmodule

// File: rtl/sft_lane.sv
module sft_lane #(
    parameter int SMP_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             load,
    input  logic             shift,
    input  logic             bit_en,
    input  logic [SMP_W-1:0] word,
    output logic             dout
);
    logic [SMP_W-1:0] sh_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q <= '0;
            dout <= 1'b0;
        end else if (clear) begin
            dout <= 1'b0;
        end else if (load) begin
            dout <= bit_en & word[SMP_W-1];
            sh_q <= word << 1;
        end else if (shift) begin
            dout <= bit_en & sh_q[SMP_W-1];
            sh_q <= sh_q << 1;
        end
    end
endmodule

// File: rtl/serial_frame_tx.sv
module serial_frame_tx
    import sft_pkg::*;
#(
    parameter int SMP_W = 24,
    parameter int IVL_W = 7,
    parameter int LEN_W = 5,
    parameter int DIV_W = 4,
    parameter int ADV_W = 2,
    parameter int NSYNC = 8,
    localparam int SEL_W = $clog2(NSYNC)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             smp_valid,
    input  logic [SMP_W-1:0] smp_i,
    input  logic [SMP_W-1:0] smp_q,
    input  logic [SMP_W-1:0] adj_q,
    input  logic [NSYNC-1:0] sync_in,
    input  logic [IVL_W-1:0] cfg_interval,
    input  logic [LEN_W-1:0] cfg_len,
    input  logic [DIV_W-1:0] cfg_div,
    input  logic [ADV_W-1:0] cfg_adv,
    input  logic [SEL_W-1:0] cfg_sync_sel,
    input  logic             cfg_adj_q,
    input  logic [NPIN-1:0]  cfg_hiz,
    output logic             ser_clk,
    output logic             fs_out,
    output logic             dout_i,
    output logic             dout_q,
    output logic [NPIN-1:0]  pin_oe
);
    logic             restart;
    logic             tick;
    sft_state_e       state_q, state_n;
    logic [IVL_W-1:0] fpos_q, fpos_n;
    logic [IVL_W-1:0] dpos_q, dpos_n;
    logic [ADV_W-1:0] lead_q, lead_n;
    logic [IVL_W-1:0] per_m1;
    logic [LEN_W:0]   word_len;
    logic             bit_en;
    logic             lane_clear, lane_load, lane_shift;
    logic [SMP_W-1:0] hold_q [NLANE];
    logic [NLANE-1:0] lane_dout;

    assign per_m1   = (cfg_interval == '0) ? '0 : cfg_interval - 1'b1;
    assign word_len = {1'b0, cfg_len} + 1'b1;
    assign bit_en   = (int'(dpos_q) < int'(word_len));
    assign pin_oe   = ~cfg_hiz;

    sft_sync_edge #(.NSYNC(NSYNC)) u_sync (
        .clk(clk), .rst_n(rst_n), .sync_in(sync_in), .sel(cfg_sync_sel), .restart(restart)
    );

    sft_bit_div #(.DIV_W(DIV_W)) u_div (
        .clk(clk), .rst_n(rst_n), .restart(restart), .div_m1(cfg_div),
        .tick(tick), .ser_clk(ser_clk)
    );

    // newest sample, Q source chosen on the way in
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int k = 0; k < int'(NLANE); k++) hold_q[k] <= '0;
        end else if (smp_valid) begin
            hold_q[0] <= smp_i;
            hold_q[1] <= cfg_adj_q ? adj_q : smp_q;
        end
    end

    // next-state and counter logic
    always_comb begin
        state_n = state_q;
        fpos_n  = fpos_q;
        dpos_n  = dpos_q;
        lead_n  = lead_q;
        if (restart) begin
            fpos_n  = '0;
            dpos_n  = '0;
            lead_n  = cfg_adv;
            state_n = (cfg_adv == '0) ? ST_DATA : ST_LEAD;
        end else if (tick) begin
            unique case (state_q)
                ST_IDLE: ;
                ST_LEAD: begin
                    fpos_n = (fpos_q >= per_m1) ? '0 : fpos_q + 1'b1;
                    lead_n = lead_q - 1'b1;
                    if (lead_q == ADV_W'(1)) state_n = ST_DATA;
                end
                ST_DATA: begin
                    fpos_n = (fpos_q >= per_m1) ? '0 : fpos_q + 1'b1;
                    dpos_n = (dpos_q >= per_m1) ? '0 : dpos_q + 1'b1;
                end
                default: ;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            fpos_q  <= '0;
            dpos_q  <= '0;
            lead_q  <= '0;
        end else begin
            state_q <= state_n;
            fpos_q  <= fpos_n;
            dpos_q  <= dpos_n;
            lead_q  <= lead_n;
        end
    end

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                          fs_out <= 1'b0;
        else if (restart)                    fs_out <= 1'b0;
        else if (tick && state_q != ST_IDLE) fs_out <= (fpos_q == '0);
    end

    assign lane_clear = restart | (tick & (state_q == ST_LEAD));
    assign lane_shift = tick & (state_q == ST_DATA);
    assign lane_load  = lane_shift & (dpos_q == '0);

    for (genvar g = 0; g < int'(NLANE); g++) begin : g_lane
        sft_lane #(.SMP_W(SMP_W)) u_lane (
            .clk(clk), .rst_n(rst_n), .clear(lane_clear), .load(lane_load),
            .shift(lane_shift), .bit_en(bit_en), .word(hold_q[g]), .dout(lane_dout[g])
        );
    end

    assign dout_i = lane_dout[0];
    assign dout_q = lane_dout[1];

    // strobe spacing checker
    int unsigned period_clks;
    int unsigned gap_cnt;
    logic        fs_prev;
    logic        gap_seen;

    assign period_clks = (int'(per_m1) + 1) * (int'(cfg_div) + 1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gap_cnt  <= 0;
            gap_seen <= 1'b0;
            fs_prev  <= 1'b0;
        end else begin
            fs_prev <= fs_out;
            if (restart) begin
                gap_cnt  <= 0;
                gap_seen <= 1'b0;
            end else if (fs_out && !fs_prev) begin
                gap_cnt  <= 1;
                gap_seen <= 1'b1;
            end else if (gap_cnt != 32'hFFFF) begin
                gap_cnt <= gap_cnt + 1;
            end
        end
    end

    assert_period_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (fs_out && !fs_prev && gap_seen) |-> gap_cnt == period_clks);

    assert_strobe_on_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fs_out) |-> $past(tick));

    assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |-> (!fs_out && !dout_i && !dout_q));

    assert_lead_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && state_q == ST_LEAD) |=> (!dout_i && !dout_q));

    assert_truncate_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && state_q == ST_DATA && !bit_en) |=> (!dout_i && !dout_q));
endmodule

// File: tb/serial_frame_tx_bench.sv
module serial_frame_tx_bench;
    localparam int W = 24;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          smp_valid = 1'b0;
    logic [W-1:0]  smp_i = '0, smp_q = '0, adj_q = '0;
    logic [7:0]    sync_in = '0;
    logic [6:0]    cfg_interval = 7'd16;
    logic [4:0]    cfg_len = 5'd15;
    logic [3:0]    cfg_div = 4'd0;
    logic [1:0]    cfg_adv = 2'd0;
    logic [2:0]    cfg_sync_sel = 3'd0;
    logic          cfg_adj_q = 1'b0;
    logic [2:0]    cfg_hiz = 3'd0;
    logic          ser_clk, fs_out, dout_i, dout_q;
    logic [2:0]    pin_oe;

    always #2 clk = ~clk;

    serial_frame_tx u_serial_frame_tx (
        .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_i(smp_i), .smp_q(smp_q),
        .adj_q(adj_q), .sync_in(sync_in), .cfg_interval(cfg_interval), .cfg_len(cfg_len),
        .cfg_div(cfg_div), .cfg_adv(cfg_adv), .cfg_sync_sel(cfg_sync_sel),
        .cfg_adj_q(cfg_adj_q), .cfg_hiz(cfg_hiz), .ser_clk(ser_clk), .fs_out(fs_out),
        .dout_i(dout_i), .dout_q(dout_q), .pin_oe(pin_oe)
    );

    int    n_tests = 0;
    int    n_fail = 0;
    bit    done = 1'b0;
    string cur_req = "R11";
    int    valid_every = 1;
    int    vcnt = 0;
    bit    noise_on = 1'b0;

    // reference model state
    int         e = 0;
    int         rq[$];
    bit         prev_s = 1'b0;
    bit         m_run = 1'b0;
    int         m_r = 0;
    logic       x_fs = 1'b0, x_di = 1'b0, x_dq = 1'b0, x_sclk = 1'b0;
    logic [W-1:0] h_i = '0, h_q = '0, w_i = '0, w_q = '0;

    task automatic check(input string req, input string what, input logic act, input logic exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %b expected %b (edge %0d)", req, what, act, exp, e);
        end
    endtask

    task automatic model_edge();
        int  dp, p, a, l, j, k;
        bit  s, rs;
        dp = int'(cfg_div) + 1;
        p  = (cfg_interval == 0) ? 1 : int'(cfg_interval);
        a  = int'(cfg_adv);
        l  = int'(cfg_len) + 1;
        if (!rst_n) begin
            e = 0; rq.delete(); prev_s = 0; m_run = 0;
            x_fs = 0; x_di = 0; x_dq = 0; x_sclk = 0;
            h_i = '0; h_q = '0; w_i = '0; w_q = '0;
            return;
        end
        e++;
        s  = sync_in[cfg_sync_sel];
        rs = (rq.size() > 0 && rq[0] == e);
        if (rs) void'(rq.pop_front());
        if (s && !prev_s) rq.push_back(e + 3);
        prev_s = s;
        if (rs) begin
            m_run = 1; m_r = e; x_fs = 0; x_di = 0; x_dq = 0;
        end else if (m_run && ((e - m_r) % dp == 0)) begin
            j = (e - m_r) / dp - 1;
            x_fs = (j % p == 0);
            if (j < a) begin
                x_di = 0; x_dq = 0;
            end else begin
                k = (j - a) % p;
                if (k == 0) begin w_i = h_i; w_q = h_q; end
                x_di = (k < l && k < W) ? w_i[W-1-k] : 1'b0;
                x_dq = (k < l && k < W) ? w_q[W-1-k] : 1'b0;
            end
        end
        if (m_run) x_sclk = (((e - m_r) % dp) < (dp / 2));
        if (smp_valid) begin
            h_i = smp_i;
            h_q = cfg_adj_q ? adj_q : smp_q;
        end
    endtask

    task automatic step();
        @(posedge clk);
        model_edge();
        #1;
        check(cur_req, "frame strobe", fs_out, x_fs);
        check(cur_req, "I lane", dout_i, x_di);
        check(cur_req, "Q lane", dout_q, x_dq);
        if (m_run) check(cur_req, "bit clock", ser_clk, x_sclk);
    endtask

    task automatic drive_samples();
        logic [7:0] r, mask;
        vcnt++;
        smp_valid = (valid_every <= 1) ? 1'b1 : (vcnt % valid_every == 0);
        smp_i = W'($urandom);
        smp_q = W'($urandom);
        adj_q = W'($urandom);
        if (noise_on) begin
            r = 8'($urandom);
            mask = 8'(1) << cfg_sync_sel;
            sync_in = (sync_in & mask) | (r & ~mask);
        end
    endtask

    task automatic run(input int n);
        for (int i = 0; i < n; i++) begin
            drive_samples();
            step();
        end
    endtask

    task automatic do_reset();
        sync_in = '0;
        rst_n = 1'b0;
        vcnt = 0;
        for (int i = 0; i < 3; i++) step();
        rst_n = 1'b1;
    endtask

    task automatic pulse(input int len);
        sync_in[cfg_sync_sel] = 1'b1;
        run(len);
        sync_in[cfg_sync_sel] = 1'b0;
    endtask

    initial begin
        // R11 and R5: quiet before sync, other sources ignored
        cur_req = "R11 R5";
        cfg_interval = 7'd16; cfg_len = 5'd15; cfg_div = 4'd1; cfg_adv = 2'd0; cfg_sync_sel = 3'd4;
        do_reset();
        check("R11", "reset strobe", fs_out, 1'b0);
        noise_on = 1'b1;
        run(60);
        check("R11", "strobe before sync", fs_out, 1'b0);
        noise_on = 1'b0;

        // R1 R2 R3 R5 R7: basic framing with a pulse sync
        cur_req = "R1 R2 R3 R5 R7";
        cfg_interval = 7'd20; cfg_len = 5'd15; cfg_div = 4'd1; cfg_adv = 2'd0; cfg_sync_sel = 3'd2;
        do_reset();
        run(5);
        pulse(1);
        noise_on = 1'b1;
        run(150);
        noise_on = 1'b0;

        // R4 R6: held level, strobe leads by three bits
        cur_req = "R4 R6";
        cfg_interval = 7'd24; cfg_len = 5'd17; cfg_div = 4'd0; cfg_adv = 2'd3; cfg_sync_sel = 3'd5;
        do_reset();
        run(3);
        sync_in[5] = 1'b1;
        run(200);
        sync_in[5] = 1'b0;
        run(20);

        // R9 R8 R4: word longer than the frame, neighbour Q
        cur_req = "R9 R8 R4";
        cfg_interval = 7'd10; cfg_len = 5'd19; cfg_div = 4'd2; cfg_adv = 2'd1; cfg_sync_sel = 3'd0;
        cfg_adj_q = 1'b1;
        do_reset();
        pulse(2);
        run(200);
        cfg_adj_q = 1'b0;

        // R1: word longer than the sample width
        cur_req = "R1";
        cfg_interval = 7'd40; cfg_len = 5'd31; cfg_div = 4'd0; cfg_adv = 2'd2; cfg_sync_sel = 3'd7;
        do_reset();
        pulse(1);
        run(140);

        // R7: decimation by two, two different sync phases
        cur_req = "R7";
        cfg_interval = 7'd12; cfg_len = 5'd11; cfg_div = 4'd1; cfg_adv = 2'd0; cfg_sync_sel = 3'd6;
        valid_every = 12;
        do_reset();
        run(4);
        pulse(1);
        run(150);
        do_reset();
        run(16);
        pulse(1);
        run(150);
        valid_every = 1;

        // R12: resync in the middle of a word
        cur_req = "R12";
        cfg_interval = 7'd30; cfg_len = 5'd23; cfg_div = 4'd3; cfg_adv = 2'd2; cfg_sync_sel = 3'd3;
        do_reset();
        pulse(1);
        run(170);
        pulse(3);
        run(260);

        // R3: widest divider
        cur_req = "R3";
        cfg_interval = 7'd5; cfg_len = 5'd4; cfg_div = 4'd15; cfg_adv = 2'd1; cfg_sync_sel = 3'd1;
        do_reset();
        pulse(1);
        run(300);

        // R2: interval 0 behaves as 1
        cur_req = "R2";
        cfg_interval = 7'd0; cfg_len = 5'd3; cfg_div = 4'd1; cfg_adv = 2'd0; cfg_sync_sel = 3'd0;
        do_reset();
        pulse(1);
        run(40);

        // R10: output enables
        for (int h = 0; h < 8; h++) begin
            cfg_hiz = 3'(h);
            #1;
            n_tests++;
            if (pin_oe !== ~3'(h)) begin
                n_fail++;
                $display("FAIL R10 output enable: actual %b expected %b", pin_oe, ~3'(h));
            end
        end
        cfg_hiz = 3'd0;

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual run still busy, expected finished");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule